// File: doc/BRIEF.md
# Stuck-bus recovery sequencer

This controller sits on the card-side segment of a two-wire serial bus. It takes the clock and data lines as already-synchronized logic levels. Each line has its own low-time counter. When either line stays low for the timeout, the block raises a disconnect request, and a connection manager uses that request to open the link to the host segment. The block then waits out a guard interval and pulses the card-side clock through an open-drain pull-low enable, a fixed number of times at most. It ends every attempt with a stop condition on the card side.

If both lines read high once the stop has been issued, the disconnect request drops and a one-cycle done pulse is given. If a line is still low, the block keeps the link open and raises a failure flag. It reconnects when the bus goes idle, or when the enable input is cycled. All durations come from a cycles-per-microsecond parameter, so a small configuration can stand in for the 30 ms timeout and the roughly 8.5 kHz burst clock.

Top module: `stuck_bus_recovery`

## Requirements
- R1: Each line's low-time counter is cleared whenever that line reads high. Lows shorter than the timeout, even if repeated, never raise `disc_o`.
- R2: A line held low for TO = TIMEOUT_US*CYC_PER_US consecutive cycles raises `disc_o` on the clock edge that follows. At a sample taken after TO edges `disc_o` is 0, and after TO+1 edges it is 1. This holds for either line.
- R3: After `disc_o` rises, no clock pull is driven for GUARD_US*CYC_PER_US cycles. The first pull starts exactly that many cycles later.
- R4: The burst is made of pulses, each with the clock pulled low for H = HALF_US*CYC_PER_US cycles and then released for H cycles. At most PULSES pulses are sent. `sda_pull_o` is 0 throughout the burst.
- R5: If both lines read high at the last cycle of a released phase, the burst ends after that pulse.
- R6: A stop condition is always issued after the burst. Both lines are pulled low together, the clock is released while data stays low, and then data is released with the clock still released. Each of these phases lasts H cycles.
- R7: When the stop completes, `done_o` pulses for one cycle. If both lines read high, `disc_o` drops. Otherwise `disc_o` stays 1 and `fail_o` is set.
- R8: While `en_i` is 0, both pull outputs are 0 in the same cycle. `disc_o` and `fail_o` are 0 from the next edge on. When `en_i` rises again the counters start from zero, so a bus that is still stuck times out again after TO+1 cycles.
- R9: In the failed state, `fail_o` and `disc_o` clear on the edge after both lines read high.
- R10: After reset, `disc_o`, `fail_o`, `done_o` and both pull outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enable; low inhibits recovery and drops the request |
| scl_i | input | 1 | Synchronized card-side clock line level |
| sda_i | input | 1 | Synchronized card-side data line level |
| scl_pull_o | output | 1 | Open-drain pull-low enable for the card-side clock |
| sda_pull_o | output | 1 | Open-drain pull-low enable for the card-side data |
| disc_o | output | 1 | Request to open the host-to-card link |
| fail_o | output | 1 | Recovery attempt ended with a line still low |
| done_o | output | 1 | One-cycle pulse when a recovery attempt finishes |

## Verification
The bench models the bus as a wired AND of the block's pulls and externally forced lows. It measures the guard gap, the width of every pulse, the pulse count and the stop ordering, all at the pull outputs. A corrupted low-time counter shifts the moment `disc_o` rises away from exactly TO+1 edges. A wrong phase length or a wrong pulse count appears in the first burst as an off-by-N width or count. A wrong outcome decision appears one cycle after the stop, in `disc_o` and `fail_o`.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GUARD,
    ST_CLK_LO,
    ST_CLK_HI,
    ST_STOP_A,
    ST_STOP_B,
    ST_STOP_C,
    ST_FAIL
  } sbr_state_e;

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sbr_line_timer.sv
module sbr_line_timer #(
  parameter int unsigned TO_CYC = 3000000,
  localparam int unsigned CW    = $clog2(TO_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic line_i,
  output logic expired_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (!run_i || line_i)       cnt_q <= '0;
    else if (cnt_q != CW'(TO_CYC))   cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q == CW'(TO_CYC));

  p_clear_on_high_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_i |=> !expired_o);
  p_expire_needs_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(expired_o) |-> $past(run_i && !line_i));
endmodule

// File: rtl/sbr_phase_timer.sv
module sbr_phase_timer #(
  parameter int unsigned PW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  input  logic [PW-1:0] len_i,
  output logic          last_o
);
  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (!last_o)   cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == len_i - 1'b1);

  p_cnt_in_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (len_i != '0 && $past(restart_i)) |-> (cnt_q == '0));
endmodule

// File: rtl/sbr_seq.sv
module sbr_seq
  import sbr_pkg::*;
#(
  parameter int unsigned G_CYC  = 4000,
  parameter int unsigned H_CYC  = 5900,
  parameter int unsigned PULSES = 16,
  parameter int unsigned PW     = 13,
  localparam int unsigned NW    = $clog2(PULSES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          stuck_i,
  input  logic          ph_last_i,
  output logic [PW-1:0] ph_len_o,
  output logic          ph_restart_o,
  output logic          run_o,
  output logic          scl_pull_o,
  output logic          sda_pull_o,
  output logic          disc_o,
  output logic          fail_o,
  output logic          done_o
);
  sbr_state_e    state_q, state_d;
  logic [NW-1:0] pcnt_q;
  logic          bus_free, burst_end;

  assign bus_free  = scl_i && sda_i;
  assign burst_end = bus_free || (pcnt_q == NW'(PULSES - 1));

  always_comb begin
    state_d = state_q;
    if (!en_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:   if (stuck_i)   state_d = ST_GUARD;
        ST_GUARD:  if (ph_last_i) state_d = ST_CLK_LO;
        ST_CLK_LO: if (ph_last_i) state_d = ST_CLK_HI;
        ST_CLK_HI: if (ph_last_i) state_d = burst_end ? ST_STOP_A : ST_CLK_LO;
        ST_STOP_A: if (ph_last_i) state_d = ST_STOP_B;
        ST_STOP_B: if (ph_last_i) state_d = ST_STOP_C;
        ST_STOP_C: if (ph_last_i) state_d = bus_free ? ST_IDLE : ST_FAIL;
        ST_FAIL:   if (bus_free)  state_d = ST_IDLE;
        default:                  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_GUARD)
        pcnt_q <= '0;
      else if (state_q == ST_CLK_HI && state_d == ST_CLK_LO)
        pcnt_q <= pcnt_q + 1'b1;
    end
  end

  assign ph_len_o     = (state_q == ST_GUARD) ? PW'(G_CYC) : PW'(H_CYC);
  assign ph_restart_o = (state_d != state_q);
  assign run_o        = en_i && (state_q == ST_IDLE);
  assign scl_pull_o   = en_i && (state_q == ST_CLK_LO || state_q == ST_STOP_A);
  assign sda_pull_o   = en_i && (state_q == ST_STOP_A || state_q == ST_STOP_B);
  assign disc_o       = (state_q != ST_IDLE);
  assign fail_o       = (state_q == ST_FAIL);
  assign done_o       = en_i && (state_q == ST_STOP_C) && ph_last_i;

  p_timeout_disc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!disc_o && en_i && stuck_i) |=> disc_o);
  p_guard_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(disc_o) |=> !scl_pull_o);
  p_pull_needs_disc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_pull_o || sda_pull_o) |-> disc_o);
  p_pulse_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pcnt_q <= NW'(PULSES - 1));
  p_stop_edge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_pull_o) |-> !scl_pull_o);
  p_fail_keeps_disc_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> disc_o);
  p_inhibit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (!scl_pull_o && !sda_pull_o));
  p_en_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!disc_o && !fail_o));
  p_fail_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_o && scl_i && sda_i) |=> !fail_o);
endmodule

// File: rtl/stuck_bus_recovery.sv
module stuck_bus_recovery
  import sbr_pkg::*;
#(
  parameter int unsigned CYC_PER_US = 100,
  parameter int unsigned TIMEOUT_US = 30000,
  parameter int unsigned GUARD_US   = 40,
  parameter int unsigned HALF_US    = 59,
  parameter int unsigned PULSES     = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_pull_o,
  output logic sda_pull_o,
  output logic disc_o,
  output logic fail_o,
  output logic done_o
);
  localparam int unsigned TO_CYC = TIMEOUT_US * CYC_PER_US;
  localparam int unsigned G_CYC  = GUARD_US * CYC_PER_US;
  localparam int unsigned H_CYC  = HALF_US * CYC_PER_US;
  localparam int unsigned PW     = $clog2(max_u(G_CYC, H_CYC) + 1);

  logic [1:0]    line_lvl, expired;
  logic          run, ph_last, ph_restart;
  logic [PW-1:0] ph_len;

  assign line_lvl = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    sbr_line_timer #(.TO_CYC(TO_CYC)) i_timer (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (run),
      .line_i    (line_lvl[g]),
      .expired_o (expired[g])
    );
  end

  sbr_phase_timer #(.PW(PW)) i_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (ph_restart),
    .len_i     (ph_len),
    .last_o    (ph_last)
  );

  sbr_seq #(
    .G_CYC  (G_CYC),
    .H_CYC  (H_CYC),
    .PULSES (PULSES),
    .PW     (PW)
  ) i_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_i),
    .scl_i        (scl_i),
    .sda_i        (sda_i),
    .stuck_i      (|expired),
    .ph_last_i    (ph_last),
    .ph_len_o     (ph_len),
    .ph_restart_o (ph_restart),
    .run_o        (run),
    .scl_pull_o   (scl_pull_o),
    .sda_pull_o   (sda_pull_o),
    .disc_o       (disc_o),
    .fail_o       (fail_o),
    .done_o       (done_o)
  );
endmodule

// File: tb/test_stuck_bus_recovery.sv
module test_stuck_bus_recovery;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int CPU = 2;
  localparam int TOU = 60;
  localparam int GU  = 5;
  localparam int HU  = 3;
  localparam int NP  = 16;
  localparam int TO  = TOU * CPU;
  localparam int G   = GU * CPU;
  localparam int H   = HU * CPU;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic ext_scl_low = 1'b0, ext_sda_low = 1'b0;
  logic scl, sda, scl_pull, sda_pull, disc, fail, done;

  int n_chk = 0, n_bad = 0;
  int smp = 0, t_disc = -1, t_clk = -1, n_burst = 0, bad_w = 0, lo_len = 0;
  int n_stop = 0, n_done = 0, rel_at = 0;
  bit stop_a_ok = 0, scl_rel_stop = 0;
  logic p_scl = 0, p_sda = 0, p_disc = 0;

  always #2.5 clk = ~clk;

  assign scl = ~scl_pull & ~ext_scl_low;
  assign sda = ~sda_pull & ~ext_sda_low;

  stuck_bus_recovery #(
    .CYC_PER_US(CPU), .TIMEOUT_US(TOU), .GUARD_US(GU), .HALF_US(HU), .PULSES(NP)
  ) i_stuck_bus_recovery (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .scl_i(scl), .sda_i(sda),
    .scl_pull_o(scl_pull), .sda_pull_o(sda_pull), .disc_o(disc),
    .fail_o(fail), .done_o(done)
  );

  // bus-side monitor: measures the sequence at the pull outputs
  always @(negedge clk) begin
    smp++;
    if (disc && !p_disc && t_disc < 0) t_disc = smp;
    if (scl_pull && !p_scl) begin
      if (t_clk < 0) t_clk = smp;
      if (!sda_pull) begin
        n_burst++;
        if (rel_at == n_burst) begin
          ext_sda_low = 1'b0;
          ext_scl_low = 1'b0;
        end
      end
      lo_len = 0;
    end
    if (!scl_pull && p_scl && !p_sda && lo_len != H) bad_w++;
    if (scl_pull) lo_len++;
    if (sda_pull && !p_sda) stop_a_ok = scl_pull;
    if (!scl_pull && p_scl && sda_pull) scl_rel_stop = 1;
    if (!sda_pull && p_sda && !scl_pull && scl_rel_stop && stop_a_ok) n_stop++;
    if (done) n_done++;
    p_scl = scl_pull; p_sda = sda_pull; p_disc = disc;
  end

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic clr();
    t_disc = -1; t_clk = -1; n_burst = 0; bad_w = 0; n_stop = 0;
    n_done = 0; rel_at = 0; stop_a_ok = 0; scl_rel_stop = 0; smp = 0;
  endtask

  task automatic wait_end(string req);
    for (int i = 0; i < 4000 && n_done == 0; i++) step(1);
    chk(req, "attempt finished", (n_done > 0) ? 1 : 0, 1);
    step(1);
  endtask

  task automatic timeout_edge(string req);
    step(TO);
    chk(req, "disc before TO+1 edges", int'(disc), 0);
    step(1);
    chk(req, "disc after TO+1 edges", int'(disc), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1; en = 1'b1;
    step(1);
    // R10 reset state
    chk("R10", "disc", int'(disc), 0);
    chk("R10", "fail", int'(fail), 0);
    chk("R10", "pulls", int'({scl_pull, sda_pull}), 0);
    chk("R10", "done", int'(done), 0);

    // R1: repeated short lows on each line, separated by one high cycle
    for (int ln = 0; ln < 2; ln++) begin
      for (int k = 0; k < 3; k++) begin
        if (ln == 0) ext_sda_low = 1; else ext_scl_low = 1;
        step(TO - 1);
        ext_sda_low = 0; ext_scl_low = 0;
        step(1);
      end
      step(2);
      chk("R1", ln == 0 ? "sda short lows" : "scl short lows", int'(disc), 0);
    end

    // R2..R7: data stuck for the whole attempt
    clr();
    ext_sda_low = 1;
    timeout_edge("R2");
    wait_end("R7");
    chk("R3", "guard gap", t_clk - t_disc, G);
    chk("R4", "burst pulses", n_burst, NP);
    chk("R4", "bad pulse widths", bad_w, 0);
    chk("R6", "stop issued", n_stop, 1);
    chk("R7", "fail after stuck", int'(fail), 1);
    chk("R7", "disc held", int'(disc), 1);
    step(20);
    chk("R7", "still failed", int'(fail), 1);

    // R9: bus frees while failed
    ext_sda_low = 0;
    step(1);
    chk("R9", "fail cleared", int'(fail), 0);
    chk("R9", "reconnected", int'(disc), 0);

    // R5: sweep the pulse after which the bus frees
    for (int k = 1; k <= 7; k += 3) begin
      clr();
      rel_at = k;
      ext_sda_low = 1;
      timeout_edge("R2");
      wait_end("R5");
      chk("R5", "early burst count", n_burst, k);
      chk("R6", "stop after early end", n_stop, 1);
      chk("R7", "recovered disc", int'(disc), 0);
      chk("R7", "recovered fail", int'(fail), 0);
      chk("R7", "done pulses", n_done, 1);
    end

    // clock line stuck: full burst, failure
    clr();
    ext_scl_low = 1;
    timeout_edge("R2");
    wait_end("R7");
    chk("R4", "burst on stuck clock", n_burst, NP);
    chk("R6", "stop on stuck clock", n_stop, 1);
    chk("R7", "fail on stuck clock", int'(fail), 1);

    // R8: enable low, then high with the clock still stuck
    en = 0;
    #0.5;
    chk("R8", "pulls while disabled", int'({scl_pull, sda_pull}), 0);
    step(1);
    chk("R8", "disc dropped", int'(disc), 0);
    chk("R8", "fail dropped", int'(fail), 0);
    step(10);
    chk("R8", "no restart while disabled", int'(disc), 0);
    clr();
    en = 1;
    timeout_edge("R8");
    rel_at = 1;
    wait_end("R8");
    chk("R5", "free after first pulse", n_burst, 1);
    chk("R7", "recovered after re-enable", int'(disc), 0);

    // R8: enable dropped in the middle of a burst
    clr();
    rel_at = 0;
    ext_sda_low = 1;
    timeout_edge("R2");
    for (int i = 0; i < 2000 && !(n_burst == 3 && scl_pull); i++) step(1);
    chk("R8", "mid-burst pull seen", int'(scl_pull), 1);
    en = 0;
    #0.5;
    chk("R8", "clock pull inhibited", int'(scl_pull), 0);
    step(1);
    chk("R8", "disc after mid-burst disable", int'(disc), 0);
    ext_sda_low = 0;
    en = 1;
    step(TO + 5);
    chk("R8", "no timeout on free bus", int'(disc), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule